// File: doc/BRIEF.md
# System Control Register File

This block is the register-transfer half of a system control coprocessor. A core hands it one move request per cycle. The request carries:

- a direction: a read moves a coprocessor value to the core, a write moves a core value into the coprocessor;
- a 4-bit primary index;
- a 4-bit secondary index;
- a 3-bit second opcode;
- a 4-bit destination register number;
- 32 bits of write data.

The block holds an identification value, the control word, and five general configuration words. These are the translation table base, the domain access word, the fault status, the fault address and the process identifier.

Writing the control word updates two outputs on the same clock edge. The exception vector base switches between zero and a high base. The MMU configuration flags are the control word masked to its low configuration bits.

Cache and TLB maintenance requests are decoded from the secondary index and turn into one-cycle invalidate pulses. One cache read form is a test-and-clean probe. It returns zero and reports that value on the N and Z condition outputs instead of producing register data. All outputs are registered, so every result appears one cycle after its request.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset every stored word, the vector base, the MMU flags and all pulse and valid outputs are zero.
- R2: Primary index 0 reads return the ID_VALUE parameter, and writes to index 0 change nothing.
- R3: A write to primary index 1 stores the control word, which reads back at index 1. On the same edge `mmu_flags` becomes the write data ANDed with MMU_MASK.
- R4: After a control write, `vec_base` is VEC_HIGH (default 0xFFFF0000) if bit 13 of the written word is 1, and 0 if it is 0.
- R5: A control write with bit 15 set drives `unsup_err` high for exactly one cycle. The word is still stored.
- R6: Primary indices 2, 3, 5, 6 and 13 each hold an independent word that reads back what was last written to it.
- R7: A write at primary index 7 pulses `icache_inval` when the secondary index is 5 or 7. Every other secondary index at index 7 pulses nothing.
- R8: A read at primary index 7 with secondary index 10 or 14 and second opcode 3 returns 0 and pulses `cond_valid` with `cond_z`=1 and `cond_n`=0. Every other index-7 read returns 0 without `cond_valid`.
- R9: At primary index 8, in either direction, the secondary index selects the effect. Index 5 or 7 pulses both `icache_inval` and `tlb_inval`. Index 6 pulses `tlb_inval` only. Every other secondary index pulses neither. Reads at index 8 return 0.
- R10: Primary indices 4, 9, 10, 11, 12, 14 and 15 read as 0, and writes to them change no readable word.
- R11: A read produces `rd_valid` with `rd_dest` equal to the request destination, but only when that destination is not 15.
- R12: Results and pulses appear on the cycle after the request and are exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_read | input | 1 | 1 = move to core (read), 0 = move to coprocessor (write) |
| req_pri | input | 4 | Primary register index |
| req_sec | input | 4 | Secondary index |
| req_op2 | input | 3 | Second opcode |
| req_dest | input | 4 | Core destination register number |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read result to be written back |
| rd_dest | output | 4 | Destination of the read result |
| rd_data | output | DATA_W | Read result |
| cond_valid | output | 1 | Condition flags update |
| cond_n | output | 1 | N flag value |
| cond_z | output | 1 | Z flag value |
| vec_base | output | DATA_W | Exception vector base |
| mmu_flags | output | DATA_W | Masked MMU configuration |
| tlb_inval | output | 1 | TLB invalidate pulse |
| icache_inval | output | 1 | Instruction page invalidate pulse |
| unsup_err | output | 1 | Unsupported control mode pulse |

## Verification
The bench keeps the default 32-bit width and mask and overrides only ID_VALUE with a distinctive pattern. With a 4-bit primary index, a 4-bit secondary index and a 3-bit opcode, the decode space is small enough to sweep exhaustively. Every primary index is written and read back, every secondary index at indices 7 and 8 is tried in both directions, and every opcode is tried against the probe form. All sixteen destination numbers are also swept.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int IDX_W  = 4;
  localparam int OP_W   = 3;
  localparam int NUM_GEN = 5;
  localparam int GEN_AW = $clog2(NUM_GEN);

  typedef enum logic [2:0] {
    K_NONE, K_ID, K_CTRL, K_GEN, K_CACHE, K_TLB
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [GEN_AW-1:0] slot;
    logic              ic_hit;
    logic              tlb_hit;
    logic              cond_hit;
  } dec_t;

  function automatic logic [GEN_AW-1:0] gen_slot(input logic [IDX_W-1:0] pri);
    case (pri)
      4'd3:    return GEN_AW'(1);
      4'd5:    return GEN_AW'(2);
      4'd6:    return GEN_AW'(3);
      4'd13:   return GEN_AW'(4);
      default: return GEN_AW'(0);
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic             rd_dir,
  input  logic [IDX_W-1:0] pri,
  input  logic [IDX_W-1:0] sec,
  input  logic [OP_W-1:0]  op2,
  output dec_t             dec
);
  logic sec_ic, sec_tlb, sec_probe;

  always_comb begin
    sec_ic    = (sec == 4'd5) || (sec == 4'd7);
    sec_tlb   = sec_ic || (sec == 4'd6);
    sec_probe = (sec == 4'd10) || (sec == 4'd14);

    dec.slot = gen_slot(pri);
    case (pri)
      4'd0:                      dec.kind = K_ID;
      4'd1:                      dec.kind = K_CTRL;
      4'd2, 4'd3, 4'd5, 4'd6,
      4'd13:                     dec.kind = K_GEN;
      4'd7:                      dec.kind = K_CACHE;
      4'd8:                      dec.kind = K_TLB;
      default:                   dec.kind = K_NONE;
    endcase

    dec.ic_hit   = ((dec.kind == K_CACHE) && !rd_dir && sec_ic) ||
                   ((dec.kind == K_TLB) && sec_ic);
    dec.tlb_hit  = (dec.kind == K_TLB) && sec_tlb;
    dec.cond_hit = (dec.kind == K_CACHE) && rd_dir && sec_probe &&
                   (op2 == OP_W'(3));
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_gen,
  input  logic              wr_ctrl,
  input  logic [GEN_AW-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] gen_rdata,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] gen_q [NUM_GEN];

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        gen_q[g] <= '0;
      else if (wr_gen && (slot == GEN_AW'(g)))
        gen_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata;
  end

  always_comb begin
    gen_rdata = '0;
    for (int i = 0; i < NUM_GEN; i++)
      if (slot == GEN_AW'(i)) gen_rdata = gen_q[i];
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0A11_0001,
  parameter logic [DATA_W-1:0] MMU_MASK = 32'h0000_030F,
  parameter logic [DATA_W-1:0] VEC_HIGH = 32'hFFFF_0000,
  parameter int              VEC_BIT  = 13,
  parameter int              ERR_BIT  = 15,
  parameter int              NO_WB    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [3:0]        req_pri,
  input  logic [3:0]        req_sec,
  input  logic [2:0]        req_op2,
  input  logic [3:0]        req_dest,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [3:0]        rd_dest,
  output logic [DATA_W-1:0] rd_data,
  output logic              cond_valid,
  output logic              cond_n,
  output logic              cond_z,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] mmu_flags,
  output logic              tlb_inval,
  output logic              icache_inval,
  output logic              unsup_err
);
  dec_t              dec;
  logic              wr_gen, wr_ctrl;
  logic [DATA_W-1:0] gen_rdata, ctrl_q, rmux;

  sysctl_decode u_dec (
    .rd_dir (req_read),
    .pri    (req_pri),
    .sec    (req_sec),
    .op2    (req_op2),
    .dec    (dec)
  );

  assign wr_gen  = req_valid && !req_read && (dec.kind == K_GEN);
  assign wr_ctrl = req_valid && !req_read && (dec.kind == K_CTRL);

  sysctl_bank #(.DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_gen    (wr_gen),
    .wr_ctrl   (wr_ctrl),
    .slot      (dec.slot),
    .wdata     (req_wdata),
    .gen_rdata (gen_rdata),
    .ctrl_q    (ctrl_q)
  );

  always_comb begin
    case (dec.kind)
      K_ID:    rmux = ID_VALUE;
      K_CTRL:  rmux = ctrl_q;
      K_GEN:   rmux = gen_rdata;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      rd_dest      <= '0;
      rd_data      <= '0;
      cond_valid   <= 1'b0;
      cond_n       <= 1'b0;
      cond_z       <= 1'b0;
      vec_base     <= '0;
      mmu_flags    <= '0;
      tlb_inval    <= 1'b0;
      icache_inval <= 1'b0;
      unsup_err    <= 1'b0;
    end else begin
      rd_valid     <= req_valid && req_read && (req_dest != 4'(NO_WB));
      rd_dest      <= req_dest;
      rd_data      <= rmux;
      cond_valid   <= req_valid && dec.cond_hit;
      cond_n       <= req_valid && dec.cond_hit && rmux[DATA_W-1];
      cond_z       <= req_valid && dec.cond_hit && (rmux == '0);
      tlb_inval    <= req_valid && dec.tlb_hit;
      icache_inval <= req_valid && dec.ic_hit;
      unsup_err    <= wr_ctrl && req_wdata[ERR_BIT];
      if (wr_ctrl) begin
        vec_base  <= req_wdata[VEC_BIT] ? VEC_HIGH : '0;
        mmu_flags <= req_wdata & MMU_MASK;
      end
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0A11_0001,
  parameter logic [DATA_W-1:0] MMU_MASK = 32'h0000_030F,
  parameter logic [DATA_W-1:0] VEC_HIGH = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_read,
  input logic [3:0]        req_pri,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [3:0]        rd_dest,
  input logic [DATA_W-1:0] rd_data,
  input logic              cond_valid,
  input logic              cond_n,
  input logic              cond_z,
  input logic [DATA_W-1:0] vec_base,
  input logic [DATA_W-1:0] mmu_flags,
  input logic              icache_inval,
  input logic              tlb_inval,
  input logic              unsup_err
);
  p_id_read_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_read && (req_pri == 4'd0) |=> rd_data == ID_VALUE);

  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_read && (req_pri == 4'd1) |=> mmu_flags == ($past(req_wdata) & MMU_MASK));

  p_vec_r4: assert property (@(posedge clk) disable iff (rst)
    (vec_base == '0) || (vec_base == VEC_HIGH));

  p_err_src_r5: assert property (@(posedge clk) disable iff (rst)
    unsup_err |-> $past(req_valid && !req_read && (req_pri == 4'd1) && req_wdata[15]));

  p_probe_flags_r8: assert property (@(posedge clk) disable iff (rst)
    cond_valid |-> cond_z && !cond_n);

  p_tlb_src_r9: assert property (@(posedge clk) disable iff (rst)
    tlb_inval |-> $past(req_valid && (req_pri == 4'd8)));

  p_ic_src_r7: assert property (@(posedge clk) disable iff (rst)
    icache_inval |-> $past(req_valid && ((req_pri == 4'd7) || (req_pri == 4'd8))));

  p_no_wb15_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_dest != 4'd15);

  p_rd_timing_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && req_read));
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .DATA_W(DATA_W), .ID_VALUE(ID_VALUE), .MMU_MASK(MMU_MASK), .VEC_HIGH(VEC_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
  .req_pri(req_pri), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_dest(rd_dest), .rd_data(rd_data), .cond_valid(cond_valid),
  .cond_n(cond_n), .cond_z(cond_z), .vec_base(vec_base),
  .mmu_flags(mmu_flags), .icache_inval(icache_inval),
  .tlb_inval(tlb_inval), .unsup_err(unsup_err)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;
  localparam logic [31:0] IDV  = 32'hC0DE_0001;
  localparam logic [31:0] MASK = 32'h0000_030F;
  localparam logic [31:0] VHI  = 32'hFFFF_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_read = 0;
  logic [3:0] req_pri = 0, req_sec = 0, req_dest = 0;
  logic [2:0] req_op2 = 0;
  logic [31:0] req_wdata = 0;
  logic rd_valid, cond_valid, cond_n, cond_z, tlb_inval, icache_inval, unsup_err;
  logic [3:0] rd_dest;
  logic [31:0] rd_data, vec_base, mmu_flags;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctl_regfile #(.ID_VALUE(IDV)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_pri(req_pri), .req_sec(req_sec), .req_op2(req_op2),
    .req_dest(req_dest), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_dest(rd_dest), .rd_data(rd_data), .cond_valid(cond_valid),
    .cond_n(cond_n), .cond_z(cond_z), .vec_base(vec_base),
    .mmu_flags(mmu_flags), .tlb_inval(tlb_inval),
    .icache_inval(icache_inval), .unsup_err(unsup_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge; return at the next falling edge with results visible
  task automatic issue(input bit rd, input logic [3:0] p, input logic [3:0] s,
                       input logic [2:0] o, input logic [3:0] d, input logic [31:0] w);
    @(negedge clk);
    req_valid = 1; req_read = rd; req_pri = p; req_sec = s;
    req_op2 = o; req_dest = d; req_wdata = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [31:0] pat(input int p);
    return 32'h3C00_0000 | (32'(p) << 16) | (32'(p) << 4);
  endfunction

  function automatic bit is_gen(input int p);
    return p == 2 || p == 3 || p == 5 || p == 6 || p == 13;
  endfunction

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 vec_base", vec_base, 0);
    chk("R1 mmu_flags", mmu_flags, 0);
    chk("R1 pulses", {28'h0, tlb_inval, icache_inval, unsup_err, cond_valid}, 0);
    for (int p = 0; p < 16; p++) begin
      issue(1, 4'(p), 0, 0, 4'd2, 0);
      exp = (p == 0) ? IDV : 32'h0;
      chk("R1 reset read", rd_data, exp);
    end

    // write every primary index (secondary 0), then read all back: R2 R3 R6 R10
    for (int p = 0; p < 16; p++) issue(0, 4'(p), 0, 0, 0, pat(p));
    for (int p = 0; p < 16; p++) begin
      issue(1, 4'(p), 0, 0, 4'd3, 0);
      if (p == 0) exp = IDV;
      else if (p == 1 || is_gen(p)) exp = pat(p);
      else exp = 0;
      chk(p == 0 ? "R2 id" : (p == 1 ? "R3 ctrl readback" :
          (is_gen(p) ? "R6 general word" : "R10 no-op index")), rd_data, exp);
      chk("R11 rd_valid", 32'(rd_valid), 1);
      chk("R11 rd_dest", 32'(rd_dest), 3);
    end

    // R3 R4 control side effects
    issue(0, 1, 0, 0, 0, 32'h0000_2FFF);
    chk("R4 vec high", vec_base, VHI);
    chk("R3 mmu flags", mmu_flags, 32'h0000_2FFF & MASK);
    chk("R5 no err", 32'(unsup_err), 0);
    issue(0, 1, 0, 0, 0, 32'hFFFF_DFFF & ~32'h8000);
    chk("R4 vec low", vec_base, 0);
    chk("R3 mmu flags 2", mmu_flags, (32'hFFFF_DFFF & ~32'h8000) & MASK);

    // R5 unsupported bit
    issue(0, 1, 0, 0, 0, 32'h0000_A001);
    chk("R5 err pulse", 32'(unsup_err), 1);
    chk("R4 vec after err", vec_base, VHI);
    @(negedge clk);
    chk("R12 err width", 32'(unsup_err), 0);
    issue(1, 1, 0, 0, 1, 0);
    chk("R5 still stored", rd_data, 32'h0000_A001);

    // R7 index 7 writes, all secondary indices
    for (int s = 0; s < 16; s++) begin
      issue(0, 7, 4'(s), 0, 0, 32'hFFFF_FFFF);
      chk("R7 icache", 32'(icache_inval), (s == 5 || s == 7) ? 1 : 0);
      chk("R7 no tlb", 32'(tlb_inval), 0);
      chk("R7 no cond", 32'(cond_valid), 0);
      @(negedge clk);
      chk("R12 ic width", 32'(icache_inval), 0);
    end

    // R8 index 7 reads, all secondary indices and opcodes
    for (int s = 0; s < 16; s++)
      for (int o = 0; o < 8; o++) begin
        issue(1, 7, 4'(s), 3'(o), 4'd4, 0);
        chk("R8 cond_valid", 32'(cond_valid), ((s == 10 || s == 14) && o == 3) ? 1 : 0);
        if (cond_valid) chk("R8 flags", {30'h0, cond_n, cond_z}, 1);
        chk("R8 data zero", rd_data, 0);
        chk("R8 no ic", 32'(icache_inval), 0);
      end
    @(negedge clk);
    chk("R12 cond width", 32'(cond_valid), 0);

    // R9 index 8 both directions
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 16; s++) begin
        issue(d[0], 8, 4'(s), 0, 4'd5, 32'h1234_5678);
        chk("R9 ic", 32'(icache_inval), (s == 5 || s == 7) ? 1 : 0);
        chk("R9 tlb", 32'(tlb_inval), (s >= 5 && s <= 7) ? 1 : 0);
        if (d == 1) chk("R9 data zero", rd_data, 0);
        @(negedge clk);
        chk("R12 tlb width", 32'(tlb_inval), 0);
      end

    // R11 destination sweep
    for (int d = 0; d < 16; d++) begin
      issue(1, 13, 0, 0, 4'(d), 0);
      chk("R11 rd_valid dest", 32'(rd_valid), d != 15 ? 1 : 0);
      if (d != 15) chk("R11 dest", 32'(rd_dest), 32'(d));
      chk("R6 pid", rd_data, pat(13));
    end

    // R12 no request -> no result
    @(negedge clk);
    chk("R12 idle", 32'(rd_valid), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule